// File: doc/BRIEF.md
# External Memory Access Arbiter

This block shares one 16-bit, output-only external address bus among three internal address sources: the X data space, the Y data space and the program space. At the start of each instruction slot it takes whatever requests are present and places them on the external bus one per cycle. While more than one request is still waiting, it holds the core in a stall. An instruction that touches one external space therefore costs no extra cycle. Two spaces cost one extra cycle, and three spaces cost two.

Each source presents a request flag and an address. When the arbiter serves a source, that source's done pulse rises for exactly one cycle. In the same cycle the external address and a two-bit space code identify the access. The core must keep its request pattern steady only in the slot-start cycle. The arbiter captures all addresses in that cycle, so later changes on the request and address inputs have no effect until the sequence ends. Because the core stalls itself, there is no back-pressure from the external side. An access on the bus always completes in the cycle it is shown.

Top module: `ext_mem_arbiter`

## Requirements
- R1: While rst_n is low, ext_valid, core_stall and all three done outputs are 0, whatever the request inputs are.
- R2: A slot with exactly one request places that source's address on ext_addr in the same cycle, with ext_valid=1 and its done=1, and does not assert core_stall.
- R3: ext_space encodes the source being served: 2'b01 for X, 2'b10 for Y, 2'b11 for program, and 2'b00 when no access is made.
- R4: When several requests are present in one slot they are served in the fixed order X, then Y, then program, one per cycle.
- R5: A slot with two requests takes two cycles; core_stall is 1 in the first and 0 in the second.
- R6: A slot with three requests takes three cycles; core_stall is 1 in the first two and 0 in the third.
- R7: At most one of x_done, y_done, p_done is high in any cycle, and it is the one matching ext_space.
- R8: Request and address inputs seen in the cycles after a slot start are ignored until the sequence ends; the addresses captured at the slot start are the ones driven.
- R9: With no request, ext_valid=0, core_stall=0 and ext_addr=16'h0000.
- R10: The cycle after a sequence's last access begins a new slot, so requests held steady are served again right away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_req | input | 1 | X data space external access request |
| x_addr | input | 16 | X data space address |
| y_req | input | 1 | Y data space external access request |
| y_addr | input | 16 | Y data space address |
| p_req | input | 1 | Program space external access request |
| p_addr | input | 16 | Program space address |
| ext_addr | output | 16 | External address bus |
| ext_space | output | 2 | Space code of the current access |
| ext_valid | output | 1 | An external access is made this cycle |
| x_done | output | 1 | X access served this cycle |
| y_done | output | 1 | Y access served this cycle |
| p_done | output | 1 | Program access served this cycle |
| core_stall | output | 1 | Core must hold its instruction this cycle |

## Verification
Every one of the eight request combinations is applied as a slot. This separates the single-access case, which has no stall, from the two-access and three-access cases, and it shows the fixed serving order for each pair. During the follow-on cycles of each multi-access slot the inputs are scrambled, which tells captured state apart from live inputs. Requests held across slots show that a new slot starts right after the last access. A reset applied with every request high shows that the outputs stay quiet.

// File: rtl/ema_pkg.sv
package ema_pkg;
  localparam int NSRC   = 3;
  localparam int ADDR_W = 16;
  localparam int CODE_W = $clog2(NSRC + 1);

  localparam int SRC_X = 0;
  localparam int SRC_Y = 1;
  localparam int SRC_P = 2;

  typedef enum logic [1:0] {
    SPC_NONE = 2'b00,
    SPC_X    = 2'b01,
    SPC_Y    = 2'b10,
    SPC_P    = 2'b11
  } space_e;
endpackage

// File: rtl/ema_prio.sv
// Fixed-priority pick: the lowest index wins.
module ema_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         more
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  // Another request is left after the one picked.
  assign more = |(req & ~gnt);
endmodule

// File: rtl/ema_hold.sv
// Captures the slot's requests and addresses, then retires one per cycle.
module ema_hold #(
  parameter int N  = 3,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  live_req,
  input  logic [N-1:0]  gnt,
  input  logic [AW-1:0] addr_in [N],
  output logic [N-1:0]  pend,
  output logic [AW-1:0] addr_q [N],
  output logic          busy
);
  assign busy = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= live_req & ~gnt;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_addr
      always_ff @(posedge clk) begin
        if (!rst_n)     addr_q[i] <= '0;
        else if (!busy) addr_q[i] <= addr_in[i];
      end
    end
  endgenerate
endmodule

// File: rtl/ema_bus_mux.sv
// AND-OR address selector plus space code from a one-hot grant.
module ema_bus_mux #(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic [N-1:0]  gnt,
  input  logic [AW-1:0] addr [N],
  output logic [AW-1:0] bus_addr,
  output logic [CW-1:0] code
);
  always_comb begin
    bus_addr = '0;
    code     = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) begin
        bus_addr = bus_addr | addr[i];
        code     = code | CW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/ext_mem_arbiter.sv
module ext_mem_arbiter
  import ema_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_req,
  input  logic [AW-1:0] x_addr,
  input  logic          y_req,
  input  logic [AW-1:0] y_addr,
  input  logic          p_req,
  input  logic [AW-1:0] p_addr,
  output logic [AW-1:0] ext_addr,
  output logic [1:0]    ext_space,
  output logic          ext_valid,
  output logic          x_done,
  output logic          y_done,
  output logic          p_done,
  output logic          core_stall
);
  logic [NSRC-1:0] in_req, pend, live_req, gnt;
  logic [AW-1:0]   in_addr [NSRC];
  logic [AW-1:0]   cap_addr [NSRC];
  logic [AW-1:0]   live_addr [NSRC];
  logic            busy, more;
  logic [AW-1:0]   mux_addr;
  logic [CODE_W-1:0] mux_code;

  assign in_req[SRC_X]  = x_req;
  assign in_req[SRC_Y]  = y_req;
  assign in_req[SRC_P]  = p_req;
  assign in_addr[SRC_X] = x_addr;
  assign in_addr[SRC_Y] = y_addr;
  assign in_addr[SRC_P] = p_addr;

  // Slot start takes live inputs; otherwise the captured leftovers.
  assign live_req = rst_n ? (busy ? pend : in_req) : '0;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_sel
      assign live_addr[i] = busy ? cap_addr[i] : in_addr[i];
    end
  endgenerate

  ema_prio #(.N(NSRC)) u_prio (
    .req  (live_req),
    .gnt  (gnt),
    .more (more)
  );

  ema_hold #(.N(NSRC), .AW(AW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_req (live_req),
    .gnt      (gnt),
    .addr_in  (in_addr),
    .pend     (pend),
    .addr_q   (cap_addr),
    .busy     (busy)
  );

  ema_bus_mux #(.N(NSRC), .AW(AW), .CW(CODE_W)) u_mux (
    .gnt      (gnt),
    .addr     (live_addr),
    .bus_addr (mux_addr),
    .code     (mux_code)
  );

  assign ext_addr   = mux_addr;
  assign ext_space  = 2'(mux_code);
  assign ext_valid  = |gnt;
  assign x_done     = gnt[SRC_X];
  assign y_done     = gnt[SRC_Y];
  assign p_done     = gnt[SRC_P];
  assign core_stall = more;
endmodule

// File: rtl/ema_arb_chk.sv
module ema_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ext_addr,
  input logic [1:0]  ext_space,
  input logic        ext_valid,
  input logic        x_done,
  input logic        y_done,
  input logic        p_done,
  input logic        core_stall
);
  // R1
  always_comb begin
    if (rst_n === 1'b0) begin
      quiet_in_reset_chk: assert (!ext_valid && !core_stall && !x_done && !y_done && !p_done);
    end
  end

  // R7
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_done, y_done, p_done}));

  // R3
  x_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_done |-> ext_space == 2'b01);

  // R3
  y_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_done |-> ext_space == 2'b10);

  // R4
  prog_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_done |-> !core_stall);

  // R5
  stall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> ext_valid);

  // R6
  max_two_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && $past(core_stall)) |=> !core_stall);

  // R8
  no_x_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_stall) |-> !x_done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_valid |-> (!core_stall && ext_addr == 16'h0000 && ext_space == 2'b00));
endmodule

bind ext_mem_arbiter ema_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_addr   (ext_addr),
  .ext_space  (ext_space),
  .ext_valid  (ext_valid),
  .x_done     (x_done),
  .y_done     (y_done),
  .p_done     (p_done),
  .core_stall (core_stall)
);

// File: tb/sim_ext_mem_arbiter.sv
module sim_ext_mem_arbiter;
  localparam int PERIOD = 10;

  // {mask p,y,x ; cycles}
  localparam logic [4:0] TBL [8] = '{
    5'b000_00, 5'b001_01, 5'b010_01, 5'b011_10,
    5'b100_01, 5'b101_10, 5'b110_10, 5'b111_11
  };

  logic clk = 0, rst_n = 0;
  logic x_req = 0, y_req = 0, p_req = 0;
  logic [15:0] x_addr = 0, y_addr = 0, p_addr = 0;
  logic [15:0] ext_addr;
  logic [1:0]  ext_space;
  logic ext_valid, x_done, y_done, p_done, core_stall;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  ext_mem_arbiter u0 (
    .clk(clk), .rst_n(rst_n),
    .x_req(x_req), .x_addr(x_addr),
    .y_req(y_req), .y_addr(y_addr),
    .p_req(p_req), .p_addr(p_addr),
    .ext_addr(ext_addr), .ext_space(ext_space), .ext_valid(ext_valid),
    .x_done(x_done), .y_done(y_done), .p_done(p_done),
    .core_stall(core_stall)
  );

  task automatic chk(input string r, input logic v, input logic [1:0] sp,
                     input logic [15:0] a, input logic st, input logic [2:0] dn);
    checks++;
    if ({ext_valid, ext_space, ext_addr, core_stall, p_done, y_done, x_done} !==
        {v, sp, a, st, dn}) begin
      fails++;
      $display("FAIL %s: got v=%b sp=%0d a=%h st=%b dn=%b exp v=%b sp=%0d a=%h st=%b dn=%b",
               r, ext_valid, ext_space, ext_addr, core_stall,
               {p_done, y_done, x_done}, v, sp, a, st, dn);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [15:0] base);
    x_req = m[0]; y_req = m[1]; p_req = m[2];
    x_addr = base + 16'h1000; y_addr = base + 16'h2000; p_addr = base + 16'h3000;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] exp_a [3];
    int order [3];
    // R1: reset with every request high
    drive(3'b111, 16'h0044);
    repeat (3) @(negedge clk);
    #1 chk("R1", 0, 2'b00, 16'h0000, 0, 3'b000);
    @(negedge clk);
    drive(3'b000, 16'h0000);
    rst_n = 1;
    #1 chk("R9", 0, 2'b00, 16'h0000, 0, 3'b000);

    // Table walk; R3 R4 R7 are checked through space, order and done fields
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m;
      int n, pos;
      m = TBL[i][4:2];
      n = int'(TBL[i][1:0]);
      @(negedge clk);
      drive(m, 16'(i * 16 + 5));
      exp_a[0] = x_addr; exp_a[1] = y_addr; exp_a[2] = p_addr;
      pos = 0;
      for (int j = 0; j < 3; j++) if (m[j]) begin order[pos] = j; pos++; end
      if (n == 0) begin
        #1 chk("R9", 0, 2'b00, 16'h0000, 0, 3'b000);
      end
      for (int c = 0; c < n; c++) begin
        string tag;
        int s;
        if (c > 0) begin
          @(negedge clk);
          // R8: scramble inputs while the sequence runs
          drive(~m | 3'b001, 16'hBEE0 + 16'(c));
        end
        tag = (c > 0) ? "R4/R8" : (n == 1) ? "R2" : (n == 2) ? "R5" : "R6";
        s = order[c];
        #1 chk(tag, 1, 2'(s + 1), exp_a[s], (c < n - 1), 3'(1 << s));
      end
    end

    // R10: X and Y held steady for two slots
    @(negedge clk);
    drive(3'b011, 16'h0700);
    #1 chk("R10", 1, 2'b01, 16'h1700, 1, 3'b001);
    @(negedge clk);
    #1 chk("R10", 1, 2'b10, 16'h2700, 0, 3'b010);
    @(negedge clk);
    drive(3'b011, 16'h0800);
    #1 chk("R10", 1, 2'b01, 16'h1800, 1, 3'b001);
    @(negedge clk);
    #1 chk("R10", 1, 2'b10, 16'h2800, 0, 3'b010);

    // R2: program alone every cycle never stalls
    @(negedge clk);
    drive(3'b100, 16'h0900);
    #1 chk("R2", 1, 2'b11, 16'h3900, 0, 3'b100);
    @(negedge clk);
    p_addr = 16'h3901;
    #1 chk("R2", 1, 2'b11, 16'h3901, 0, 3'b100);

    // R8: new X request arrives mid-sequence of Y and P
    @(negedge clk);
    drive(3'b110, 16'h0A00);
    #1 chk("R5", 1, 2'b10, 16'h2A00, 1, 3'b010);
    @(negedge clk);
    drive(3'b001, 16'h0B00);
    #1 chk("R8", 1, 2'b11, 16'h3A00, 0, 3'b100);
    @(negedge clk);
    #1 chk("R8", 1, 2'b01, 16'h1B00, 0, 3'b001);

    // R1: reset in the middle of a sequence
    @(negedge clk);
    drive(3'b111, 16'h0C00);
    #1 chk("R6", 1, 2'b01, 16'h1C00, 1, 3'b001);
    rst_n = 0;
    #1 chk("R1", 0, 2'b00, 16'h0000, 0, 3'b000);
    @(negedge clk);
    drive(3'b000, 16'h0000);
    rst_n = 1;
    #1 chk("R9", 0, 2'b00, 16'h0000, 0, 3'b000);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule